// File: doc/BRIEF.md
# Two-Level Hierarchical Interrupt Controller

This block gathers interrupt requests from on-chip peripherals and presents them to a processor on six active-low lines: one non-maskable line (`nmi_n`) and five maskable lines (`irq_n[4:0]`). Peripheral sources are arranged in groups. Each group owns a second-level pending register and a second-level mask register. The enabled bits of a group are OR-reduced into one bit of the first-level pending register. Three sources have no group and set their first-level bits directly: a battery-fault source and two long-period timers. The first-level pending register is gated by a first-level mask and then routed onto the processor lines.

The battery-fault source is routed to one of two places, chosen by a software-written routing bit. It can go to the non-maskable line, where no mask affects it. Otherwise it goes through the first-level mask onto maskable line 0. Timer 1 has line 1 to itself and timer 2 has line 2 to itself. Every other enabled first-level request is ORed onto line 0. Lines 3 and 4 are unused and stay high.

Software reaches all pending, mask and routing registers through a single-cycle register port. Writes take effect on the clock edge. Reads are combinational.

Top module: `irq_hier_ctrl`

## Requirements
- R1: The battery (first-level bit 0), timer 1 (bit 1) and timer 2 (bit 2) pending bits are set by their source. A bit stays set until software writes 1 to that bit position at address 0. When the source is high in the same cycle as the clearing write, the bit stays set.
- R2: A group configured as latched sets pending bit i of group g when source bit i is high. The bit stays set until a write of 1 to bit i at address 4+2g. Set wins over clear.
- R3: A group configured as level-type shows its source bits, delayed by one clock, in its pending register. Writes to its pending address have no effect.
- R4: First-level bit 3+g reads as the OR of (group g pending AND group g mask). Address 0 reads the full first-level pending vector.
- R5: The first-level mask sits at address 1, and a bit of 1 enables the matching pending bit. The processor lines are registered and change exactly one clock after the pending, mask or routing state changes.
- R6: Routing bit 0 at address 2 steers the battery source. When it is 1, a pending battery bit drives `nmi_n` low regardless of the first-level mask and does not reach `irq_n[0]`. When it is 0, `nmi_n` stays high and the masked battery bit joins `irq_n[0]`.
- R7: The enabled timer 1 bit drives only `irq_n[1]` low. The enabled timer 2 bit drives only `irq_n[2]` low.
- R8: Every enabled group bit drives `irq_n[0]` low.
- R9: `irq_n[4:3]` are always 1. All processor lines are active-low.
- R10: Reset clears every pending, mask and routing register and sets every processor line high.
- R11: The group mask for group g sits at address 5+2g. Unmapped addresses read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_src | input | NUM_GRP*GRP_W | Group request inputs, group g at bits [g*GRP_W +: GRP_W] |
| bat_src | input | 1 | Battery-fault request |
| tmr1_src | input | 1 | Long-period timer 1 request |
| tmr2_src | input | 1 | Long-period timer 2 request |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |
| nmi_n | output | 1 | Non-maskable interrupt, active-low |
| irq_n | output | 5 | Maskable interrupt lines, active-low |

## Verification
The two functions that can land in the same cycle are a new request from a source and software's write-one clear of that source's pending bit. The bench provokes this by holding the battery source high during the clearing write to address 0. It judges the result by reading the bit back as still set and by checking that the routed line stays low. A second collision is a mask or routing write arriving while requests are pending. A full sweep of first-level mask and routing values covers this, and every output is compared one clock after the write against a model computed in the bench.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int BAT_IDX  = 0;
  localparam int T1_IDX   = 1;
  localparam int T2_IDX   = 2;
  localparam int DIR_N    = 3;
  localparam int ADDR_L1P   = 0;
  localparam int ADDR_L1M   = 1;
  localparam int ADDR_ROUTE = 2;
  localparam int ADDR_GRP_BASE = 4;
  localparam int CPU_LINES = 5;

  typedef enum logic {
    ROUTE_LINE0 = 1'b0,
    ROUTE_NMI   = 1'b1
  } bat_route_e;

  function automatic int grp_pend_addr(input int g);
    return ADDR_GRP_BASE + 2 * g;
  endfunction

  function automatic int grp_mask_addr(input int g);
    return ADDR_GRP_BASE + 2 * g + 1;
  endfunction
endpackage

// File: rtl/icu_rst_sync.sv
module icu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/icu_group_reg.sv
module icu_group_reg #(
  parameter int GRP_W     = 4,
  parameter int AW        = 4,
  parameter bit LEVEL     = 1'b0,
  parameter int PEND_ADDR = 4,
  parameter int MASK_ADDR = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GRP_W-1:0] src,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [GRP_W-1:0] wdata,
  output logic [GRP_W-1:0] pend,
  output logic [GRP_W-1:0] mask,
  output logic             req
);
  logic [GRP_W-1:0] pend_q, pend_d;
  logic [GRP_W-1:0] mask_q, mask_d;
  logic             mask_en;

  always_comb begin
    mask_en = we && (addr == AW'(MASK_ADDR));
    mask_d  = wdata;
  end

  generate
    if (LEVEL) begin : g_level
      // level-type: pending mirrors the source, software writes ignored
      always_comb pend_d = src;
    end else begin : g_latch
      logic             clr_hit;
      logic [GRP_W-1:0] clr_bits;
      always_comb begin
        clr_hit  = we && (addr == AW'(PEND_ADDR));
        clr_bits = clr_hit ? wdata : '0;
        // a new request beats a simultaneous clear
        pend_d   = (pend_q & ~clr_bits) | src;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (mask_en) mask_q <= mask_d;
    end
  end

  assign pend = pend_q;
  assign mask = mask_q;
  assign req  = |(pend_q & mask_q);
endmodule

// File: rtl/icu_l1_reg.sv
module icu_l1_reg
  import icu_pkg::*;
#(
  parameter int AW      = 4,
  parameter int NUM_GRP = 3,
  localparam int L1W    = DIR_N + NUM_GRP
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DIR_N-1:0]   dir_src,
  input  logic [NUM_GRP-1:0] grp_req,
  input  logic               we,
  input  logic [AW-1:0]      addr,
  input  logic [L1W-1:0]     wdata,
  output logic [L1W-1:0]     l1_pend,
  output logic [L1W-1:0]     l1_mask,
  output bat_route_e         route
);
  logic [DIR_N-1:0] dir_q, dir_d, clr_bits;
  logic [L1W-1:0]   mask_q, mask_d;
  bat_route_e       route_q, route_d;
  logic             mask_en, route_en;

  always_comb begin
    clr_bits = (we && (addr == AW'(ADDR_L1P))) ? wdata[DIR_N-1:0] : '0;
    dir_d    = (dir_q & ~clr_bits) | dir_src;
    mask_en  = we && (addr == AW'(ADDR_L1M));
    mask_d   = wdata;
    route_en = we && (addr == AW'(ADDR_ROUTE));
    route_d  = bat_route_e'(wdata[0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      mask_q  <= '0;
      route_q <= ROUTE_LINE0;
    end else begin
      dir_q <= dir_d;
      if (mask_en)  mask_q  <= mask_d;
      if (route_en) route_q <= route_d;
    end
  end

  assign l1_pend = {grp_req, dir_q};
  assign l1_mask = mask_q;
  assign route   = route_q;
endmodule

// File: rtl/icu_line_router.sv
module icu_line_router
  import icu_pkg::*;
#(
  parameter int L1W = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [L1W-1:0]       l1_pend,
  input  logic [L1W-1:0]       l1_mask,
  input  bat_route_e           route,
  output logic                 nmi_n,
  output logic [CPU_LINES-1:0] irq_n
);
  logic [L1W-1:0]       enabled;
  logic                 line0_req;
  logic                 nmi_d;
  logic [CPU_LINES-1:0] irq_d;

  always_comb begin
    enabled   = l1_pend & l1_mask;
    line0_req = ((route == ROUTE_LINE0) && enabled[BAT_IDX])
              || (|enabled[L1W-1:DIR_N]);
    nmi_d     = !((route == ROUTE_NMI) && l1_pend[BAT_IDX]);
    irq_d     = {2'b11, !enabled[T2_IDX], !enabled[T1_IDX], !line0_req};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_n <= 1'b1;
      irq_n <= '1;
    end else begin
      nmi_n <= nmi_d;
      irq_n <= irq_d;
    end
  end
endmodule

// File: rtl/irq_hier_ctrl.sv
module irq_hier_ctrl
  import icu_pkg::*;
#(
  parameter int NUM_GRP       = 3,
  parameter int GRP_W         = 4,
  parameter int DW            = 16,
  parameter int AW            = 4,
  parameter bit [NUM_GRP-1:0] GRP_LEVEL = 3'b010,
  localparam int L1W          = DIR_N + NUM_GRP
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_GRP*GRP_W-1:0] grp_src,
  input  logic                     bat_src,
  input  logic                     tmr1_src,
  input  logic                     tmr2_src,
  input  logic                     reg_we,
  input  logic [AW-1:0]            reg_addr,
  input  logic [DW-1:0]            reg_wdata,
  output logic [DW-1:0]            reg_rdata,
  output logic                     nmi_n,
  output logic [4:0]               irq_n
);
  logic                 rst_sync_n;
  logic [GRP_W-1:0]     grp_pend [NUM_GRP];
  logic [GRP_W-1:0]     grp_mask [NUM_GRP];
  logic [NUM_GRP-1:0]   grp_req;
  logic [L1W-1:0]       l1_pend;
  logic [L1W-1:0]       l1_mask;
  bat_route_e           route_sel;
  logic                 route_nmi;
  logic                 wdata_unused;

  assign wdata_unused = ^reg_wdata;
  assign route_nmi    = (route_sel == ROUTE_NMI);

  icu_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  generate
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      icu_group_reg #(
        .GRP_W     (GRP_W),
        .AW        (AW),
        .LEVEL     (GRP_LEVEL[g]),
        .PEND_ADDR (grp_pend_addr(g)),
        .MASK_ADDR (grp_mask_addr(g))
      ) u_grp (
        .clk   (clk),
        .rst_n (rst_sync_n),
        .src   (grp_src[g*GRP_W +: GRP_W]),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata[GRP_W-1:0]),
        .pend  (grp_pend[g]),
        .mask  (grp_mask[g]),
        .req   (grp_req[g])
      );
    end
  endgenerate

  icu_l1_reg #(
    .AW      (AW),
    .NUM_GRP (NUM_GRP)
  ) u_l1 (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .dir_src ({tmr2_src, tmr1_src, bat_src}),
    .grp_req (grp_req),
    .we      (reg_we),
    .addr    (reg_addr),
    .wdata   (reg_wdata[L1W-1:0]),
    .l1_pend (l1_pend),
    .l1_mask (l1_mask),
    .route   (route_sel)
  );

  icu_line_router #(
    .L1W (L1W)
  ) u_route (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .l1_pend (l1_pend),
    .l1_mask (l1_mask),
    .route   (route_sel),
    .nmi_n   (nmi_n),
    .irq_n   (irq_n)
  );

  // read mux: unmapped addresses return zero
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(ADDR_L1P))   reg_rdata = DW'(l1_pend);
    if (reg_addr == AW'(ADDR_L1M))   reg_rdata = DW'(l1_mask);
    if (reg_addr == AW'(ADDR_ROUTE)) reg_rdata = DW'(route_nmi);
    for (int g = 0; g < NUM_GRP; g++) begin
      if (reg_addr == AW'(grp_pend_addr(g))) reg_rdata = DW'(grp_pend[g]);
      if (reg_addr == AW'(grp_mask_addr(g))) reg_rdata = DW'(grp_mask[g]);
    end
  end
endmodule

// File: rtl/irq_hier_ctrl_chk.sv
module irq_hier_ctrl_chk #(
  parameter int L1W = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bat_src,
  input logic [L1W-1:0] l1_pend,
  input logic [L1W-1:0] l1_mask,
  input logic           route_nmi,
  input logic           nmi_n,
  input logic [4:0]     irq_n
);
  // R1: a battery request is pending on the next cycle
  a_r1_bat_latched: assert property (@(posedge clk) disable iff (!rst_n)
    bat_src |=> l1_pend[0]);

  // R6: routed to the non-maskable line, the mask has no say
  a_r6_nmi_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    (route_nmi && l1_pend[0]) |=> !nmi_n);

  // R6: routed to line 0, the non-maskable line stays idle
  a_r6_nmi_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !route_nmi |=> nmi_n);

  // R7: enabled timer 1 pulls line 1
  a_r7_timer1_line: assert property (@(posedge clk) disable iff (!rst_n)
    (l1_pend[1] && l1_mask[1]) |=> !irq_n[1]);

  // R5: a cleared mask bit keeps timer 2 off its line
  a_r5_timer2_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !l1_mask[2] |=> irq_n[2]);

  // R8: any enabled group bit pulls line 0
  a_r8_group_line0: assert property (@(posedge clk) disable iff (!rst_n)
    (|(l1_pend[L1W-1:3] & l1_mask[L1W-1:3])) |=> !irq_n[0]);

  // R9: unused lines never go active
  a_r9_spare_idle: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_n[4:3] == 2'b11));
endmodule

bind irq_hier_ctrl irq_hier_ctrl_chk #(.L1W(L1W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bat_src   (bat_src),
  .l1_pend   (l1_pend),
  .l1_mask   (l1_mask),
  .route_nmi (route_nmi),
  .nmi_n     (nmi_n),
  .irq_n     (irq_n)
);

// File: tb/sim_irq_hier_ctrl.sv
`timescale 1ns/1ps
module sim_irq_hier_ctrl;
  localparam int NUM_GRP = 3;
  localparam int GRP_W   = 4;
  localparam int DW      = 16;
  localparam int AW      = 4;
  localparam bit [NUM_GRP-1:0] GRP_LEVEL = 3'b010;
  localparam int L1W     = 3 + NUM_GRP;

  logic                     clk = 1'b0;
  logic                     rst_n;
  logic [NUM_GRP*GRP_W-1:0] grp_src;
  logic                     bat_src, tmr1_src, tmr2_src;
  logic                     reg_we;
  logic [AW-1:0]            reg_addr;
  logic [DW-1:0]            reg_wdata;
  logic [DW-1:0]            reg_rdata;
  logic                     nmi_n;
  logic [4:0]               irq_n;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  irq_hier_ctrl #(
    .NUM_GRP(NUM_GRP), .GRP_W(GRP_W), .DW(DW), .AW(AW), .GRP_LEVEL(GRP_LEVEL)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .grp_src(grp_src), .bat_src(bat_src),
    .tmr1_src(tmr1_src), .tmr2_src(tmr2_src), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .nmi_n(nmi_n), .irq_n(irq_n)
  );

  // ---------------- behavioural model from the requirements ----------------
  logic [2:0]       m_dir;
  logic [L1W-1:0]   m_l1m;
  logic             m_route;
  logic [GRP_W-1:0] m_gp [NUM_GRP];
  logic [GRP_W-1:0] m_gm [NUM_GRP];
  logic             m_nmi_n;
  logic [4:0]       m_irq_n;
  logic [L1W-1:0]   m_l1p;
  logic [L1W-1:0]   m_en;

  always_comb begin
    m_l1p[2:0] = m_dir;
    for (int g = 0; g < NUM_GRP; g++) m_l1p[3+g] = |(m_gp[g] & m_gm[g]);
    m_en = m_l1p & m_l1m;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir <= '0; m_l1m <= '0; m_route <= 1'b0;
      for (int g = 0; g < NUM_GRP; g++) begin m_gp[g] <= '0; m_gm[g] <= '0; end
      m_nmi_n <= 1'b1; m_irq_n <= 5'b11111;
    end else begin
      m_dir <= (m_dir & ~((reg_we && reg_addr == 0) ? reg_wdata[2:0] : 3'b000))
               | {tmr2_src, tmr1_src, bat_src};
      if (reg_we && reg_addr == 1) m_l1m <= reg_wdata[L1W-1:0];
      if (reg_we && reg_addr == 2) m_route <= reg_wdata[0];
      for (int g = 0; g < NUM_GRP; g++) begin
        if (GRP_LEVEL[g]) m_gp[g] <= grp_src[g*GRP_W +: GRP_W];
        else m_gp[g] <= (m_gp[g] & ~((reg_we && reg_addr == AW'(4+2*g)) ?
                         reg_wdata[GRP_W-1:0] : '0)) | grp_src[g*GRP_W +: GRP_W];
        if (reg_we && reg_addr == AW'(5+2*g)) m_gm[g] <= reg_wdata[GRP_W-1:0];
      end
      m_nmi_n <= !(m_route && m_dir[0]);
      m_irq_n <= {2'b11, !m_en[2], !m_en[1],
                  !((!m_route && m_en[0]) || (|m_en[L1W-1:3]))};
    end
  end

  function automatic logic [DW-1:0] m_read(input int a);
    m_read = '0;
    if (a == 0) m_read = DW'(m_l1p);
    if (a == 1) m_read = DW'(m_l1m);
    if (a == 2) m_read = DW'(m_route);
    for (int g = 0; g < NUM_GRP; g++) begin
      if (a == 4 + 2*g) m_read = DW'(m_gp[g]);
      if (a == 5 + 2*g) m_read = DW'(m_gm[g]);
    end
  endfunction

  function automatic string tag_of(input int a);
    if (a == 0) return "R4";
    if (a == 1) return "R5";
    if (a == 2) return "R6";
    if (a >= 4 && a < 4 + 2*NUM_GRP) return ((a % 2) == 0) ? "R2" : "R11";
    return "R11";
  endfunction

  // ---------------- check helpers ----------------
  task automatic chk(input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic chk_all(input string tag);
    chk(tag, "nmi_n", DW'(nmi_n), DW'(m_nmi_n));
    chk(tag, "irq_n", DW'(irq_n), DW'(m_irq_n));
    chk("R9", "irq_n spare lines", DW'(irq_n[4:3]), DW'(2'b11));
    for (int a = 0; a < (1 << AW); a++) begin
      reg_addr = AW'(a);
      #1;
      chk(tag_of(a), $sformatf("read addr %0d", a), reg_rdata, m_read(a));
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    rst_n = 1'b0; grp_src = '0; bat_src = 1'b0; tmr1_src = 1'b0; tmr2_src = 1'b0;
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    chk_all("R10");
    rst_n = 1'b1;
    repeat (4) tick();
    chk_all("R10");

    // R2 R4 R8: latched groups, all mask and source combinations
    wr(1, DW'((1 << L1W) - 1));
    for (int g = 0; g < NUM_GRP; g++) begin
      if (!GRP_LEVEL[g]) begin
        for (int m = 0; m < (1 << GRP_W); m++) begin
          for (int s = 0; s < (1 << GRP_W); s++) begin
            wr(4 + 2*g, DW'((1 << GRP_W) - 1));
            wr(5 + 2*g, DW'(m));
            grp_src[g*GRP_W +: GRP_W] = GRP_W'(s);
            tick();
            grp_src = '0;
            chk("R2", "pending set", DW'(m_gp[g]), DW'(s));
            tick();
            chk_all("R8");
          end
        end
        wr(4 + 2*g, DW'((1 << GRP_W) - 1));
        wr(5 + 2*g, '0);
      end
    end

    // R3: level groups follow the source, clear writes ignored
    for (int g = 0; g < NUM_GRP; g++) begin
      if (GRP_LEVEL[g]) begin
        for (int m = 0; m < (1 << GRP_W); m += 5) begin
          for (int s = 1; s < (1 << GRP_W); s++) begin
            wr(5 + 2*g, DW'(m));
            grp_src[g*GRP_W +: GRP_W] = GRP_W'(s);
            tick(); tick();
            wr(4 + 2*g, DW'((1 << GRP_W) - 1));
            reg_addr = AW'(4 + 2*g); #1;
            chk("R3", "level pending after clear write", reg_rdata, DW'(s));
            chk_all("R3");
            grp_src = '0;
            tick();
            reg_addr = AW'(4 + 2*g); #1;
            chk("R3", "level pending follows release", reg_rdata, '0);
            tick();
            chk_all("R3");
          end
        end
        wr(5 + 2*g, '0);
      end
    end

    // R5 R6 R7: pend direct sources and one group bit, sweep mask and routing
    wr(5, DW'(1));
    bat_src = 1'b1; tmr1_src = 1'b1; tmr2_src = 1'b1; grp_src[0] = 1'b1;
    tick();
    bat_src = 1'b0; tmr1_src = 1'b0; tmr2_src = 1'b0; grp_src = '0;
    for (int r = 0; r < 2; r++) begin
      for (int m = 0; m < (1 << L1W); m++) begin
        wr(2, DW'(r));
        wr(1, DW'(m));
        chk("R5", "no change before one clock", DW'(irq_n), DW'(m_irq_n));
        tick();
        chk_all((r == 1) ? "R6" : "R7");
      end
    end

    // R1: source high during its clearing write keeps the bit set
    wr(2, DW'(0));
    wr(1, DW'(1));
    bat_src = 1'b1;
    wr(0, DW'(1));
    bat_src = 1'b0;
    reg_addr = 0; #1;
    chk("R1", "set beats clear", DW'(reg_rdata[0]), DW'(1));
    tick();
    chk("R1", "line 0 held low", DW'(irq_n[0]), DW'(0));
    chk_all("R1");
    wr(0, DW'(7));
    reg_addr = 0; #1;
    chk("R1", "cleared by write-one", DW'(reg_rdata[2:0]), DW'(0));
    tick();
    chk_all("R1");

    // R11: unmapped writes and reads
    for (int a = 3; a < (1 << AW); a++) begin
      if (a == 3 || a >= 4 + 2*NUM_GRP) begin
        wr(a, '1);
        tick();
        chk_all("R11");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule